// File: doc/BRIEF.md
# Integer Arithmetic Compare Unit

This is a purely combinational 64-bit integer unit for the execute stage of a processor pipeline. It takes two operands and a 7-bit function code and returns a 64-bit result. Operand B reaches the unit already resolved: it is either a register value or a small literal that has been zero-extended upstream. The unit covers three kinds of operation. The first is add and subtract at two widths, a 32-bit longword and a 64-bit quadword. The second is variants of these that first scale operand A by 4 or by 8. The third is a set of compare operations.

The overflow-checking add and subtract codes raise a trap flag when signed overflow occurs. The unit does not deliver the trap. It always presents the wrapped result, and the surrounding pipeline decides what to do with the flag. Longword results are sign-extended from bit 31 to the full width. A byte-parallel compare returns an 8-bit mask with one bit per byte lane. A function code the unit does not recognise gives a zero result and raises a separate illegal-function flag.

Top module: `iacu_top`

## Requirements
- R1: Codes 0x00 (longword) and 0x20 (quadword) give opa+opb modulo the operation width. A longword result is the low 32 bits of the sum, sign-extended from bit 31 to 64 bits.
- R2: Codes 0x09 (longword) and 0x29 (quadword) give opa-opb, with the same wrapping and sign-extension rules as R1.
- R3: The scaled codes shift opa left before the add or subtract. Codes 0x02, 0x22, 0x0b and 0x2b shift by 2. Codes 0x12, 0x32, 0x1b and 0x3b shift by 3. Codes 0x02, 0x12, 0x0b and 0x1b are longword forms (R1 rules). Codes 0x22, 0x32, 0x2b and 0x3b are quadword forms. Codes 0x02, 0x12, 0x22 and 0x32 add. Codes 0x0b, 0x1b, 0x2b and 0x3b subtract.
- R4: Codes 0x40 (longword) and 0x60 (quadword) add like R1. They set ovf_trap when the sign bits of opa and opb are equal and the sign bit of the sum differs from that of opa. The sign bit is bit 31 for longword and bit 63 for quadword.
- R5: Codes 0x49 (longword) and 0x69 (quadword) subtract like R2. They set ovf_trap when the sign bits of opa and opb differ and the sign bit of the difference differs from that of opa.
- R6: ovf_trap is 0 for every code other than 0x40, 0x60, 0x49 and 0x69. When ovf_trap is 1, result still carries the wrapped value.
- R7: The compare codes write 1 when their condition holds and 0 otherwise. The conditions are: 0x2d equal, 0x4d signed less-than, 0x6d signed less-or-equal, 0x1d unsigned less-than, 0x3d unsigned less-or-equal.
- R8: Code 0x0f sets result bit i (i = 0..7) when byte i of opa, taken as unsigned, is greater than or equal to byte i of opb. Byte i is bits 8i+7..8i. Result bits 63..8 are 0.
- R9: Any code not listed in R1 to R8 drives result to 0, bad_func to 1 and ovf_trap to 0. Every listed code drives bad_func to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B (register value or zero-extended literal) |
| func | input | 7 | Function code |
| result | output | 64 | Computed result |
| ovf_trap | output | 1 | Signed overflow on a checking add or subtract |
| bad_func | output | 1 | Function code not recognised |

## Verification
The checks assume that the operands and the function code carry known values whenever they are evaluated. The checks are skipped while any input bit is unknown, so the undriven time before reset releases cannot trip them. The bench drives every input from the first cycle and changes it only on the rising clock edge. The unit has no internal state, so nothing about the input sequence is assumed. Every code, legal or not, may follow any other. The random phase therefore mixes codes and operand sign patterns freely.

// File: rtl/iacu_pkg.sv
package iacu_pkg;
   localparam int FUNC_W = 7;

   typedef enum logic [3:0] {
      K_ADD  = 4'd0,
      K_SUB  = 4'd1,
      K_CEQ  = 4'd2,
      K_CLT  = 4'd3,
      K_CLE  = 4'd4,
      K_CULT = 4'd5,
      K_CULE = 4'd6,
      K_BGE  = 4'd7,
      K_BAD  = 4'd8
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic       lw;
      logic [1:0] shamt;
      logic       chk;
   } ctl_t;
endpackage

// File: rtl/iacu_decode.sv
module iacu_decode
   import iacu_pkg::*;
(
   input  logic [FUNC_W-1:0] func,
   output ctl_t              ctl
);
   function automatic ctl_t mk(kind_e k, logic l, logic [1:0] s, logic c);
      ctl_t t;
      t.kind  = k;
      t.lw    = l;
      t.shamt = s;
      t.chk   = c;
      return t;
   endfunction

   always_comb begin
      unique case (func)
         7'h00: ctl = mk(K_ADD, 1'b1, 2'd0, 1'b0);
         7'h02: ctl = mk(K_ADD, 1'b1, 2'd2, 1'b0);
         7'h12: ctl = mk(K_ADD, 1'b1, 2'd3, 1'b0);
         7'h20: ctl = mk(K_ADD, 1'b0, 2'd0, 1'b0);
         7'h22: ctl = mk(K_ADD, 1'b0, 2'd2, 1'b0);
         7'h32: ctl = mk(K_ADD, 1'b0, 2'd3, 1'b0);
         7'h40: ctl = mk(K_ADD, 1'b1, 2'd0, 1'b1);
         7'h60: ctl = mk(K_ADD, 1'b0, 2'd0, 1'b1);
         7'h09: ctl = mk(K_SUB, 1'b1, 2'd0, 1'b0);
         7'h0b: ctl = mk(K_SUB, 1'b1, 2'd2, 1'b0);
         7'h1b: ctl = mk(K_SUB, 1'b1, 2'd3, 1'b0);
         7'h29: ctl = mk(K_SUB, 1'b0, 2'd0, 1'b0);
         7'h2b: ctl = mk(K_SUB, 1'b0, 2'd2, 1'b0);
         7'h3b: ctl = mk(K_SUB, 1'b0, 2'd3, 1'b0);
         7'h49: ctl = mk(K_SUB, 1'b1, 2'd0, 1'b1);
         7'h69: ctl = mk(K_SUB, 1'b0, 2'd0, 1'b1);
         7'h2d: ctl = mk(K_CEQ, 1'b0, 2'd0, 1'b0);
         7'h4d: ctl = mk(K_CLT, 1'b0, 2'd0, 1'b0);
         7'h6d: ctl = mk(K_CLE, 1'b0, 2'd0, 1'b0);
         7'h1d: ctl = mk(K_CULT, 1'b0, 2'd0, 1'b0);
         7'h3d: ctl = mk(K_CULE, 1'b0, 2'd0, 1'b0);
         7'h0f: ctl = mk(K_BGE, 1'b0, 2'd0, 1'b0);
         default: ctl = mk(K_BAD, 1'b0, 2'd0, 1'b0);
      endcase
   end
endmodule

// File: rtl/iacu_addsub.sv
module iacu_addsub #(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              lw,
   input  logic [1:0]        shamt,
   input  logic              chk,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);
   localparam int EXT_W = DATA_W - WORD_W;

   logic [DATA_W-1:0] a_q, r_q;
   logic [WORD_W-1:0] a_l, r_l;
   logic              sa, sb, sr, signs_hit;

   // Separate narrow path: its carry chain stops at bit WORD_W-1.
   always_comb begin
      a_q = a << shamt;
      a_l = a[WORD_W-1:0] << shamt;
      r_q = sub ? (a_q - b) : (a_q + b);
      r_l = sub ? (a_l - b[WORD_W-1:0]) : (a_l + b[WORD_W-1:0]);
   end

   always_comb begin
      if (lw) begin
         res = {{EXT_W{r_l[WORD_W-1]}}, r_l};
         sa  = a[WORD_W-1];
         sb  = b[WORD_W-1];
         sr  = r_l[WORD_W-1];
      end else begin
         res = r_q;
         sa  = a[DATA_W-1];
         sb  = b[DATA_W-1];
         sr  = r_q[DATA_W-1];
      end
      signs_hit = sub ? (sa != sb) : (sa == sb);
      ovf       = chk & signs_hit & (sr != sa);
   end
endmodule

// File: rtl/iacu_cmp.sv
module iacu_cmp
   import iacu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  kind_e             kind,
   output logic [DATA_W-1:0] res
);
   logic eq, lt_s, lt_u, hit;

   always_comb begin
      eq   = (a == b);
      lt_s = ($signed(a) < $signed(b));
      lt_u = (a < b);
      unique case (kind)
         K_CEQ:   hit = eq;
         K_CLT:   hit = lt_s;
         K_CLE:   hit = lt_s | eq;
         K_CULT:  hit = lt_u;
         K_CULE:  hit = lt_u | eq;
         default: hit = 1'b0;
      endcase
      res = {{(DATA_W-1){1'b0}}, hit};
   end
endmodule

// File: rtl/iacu_bytecmp.sv
module iacu_bytecmp #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);
   localparam int LANES = DATA_W / LANE_W;

   logic [LANES-1:0] mask;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = (a[i*LANE_W +: LANE_W] >= b[i*LANE_W +: LANE_W]);
   end

   assign res = {{(DATA_W-LANES){1'b0}}, mask};
endmodule

// File: rtl/iacu_top.sv
module iacu_top
   import iacu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [FUNC_W-1:0] func,
   output logic [DATA_W-1:0] result,
   output logic              ovf_trap,
   output logic              bad_func
);
   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_chk_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (WORD_W >= DATA_W || WORD_W < 2) begin : g_chk_word
      $error("WORD_W must lie between 2 and DATA_W-1");
   end
   if (LANES > DATA_W - 1) begin : g_chk_cnt
      $error("lane count must leave room for zero upper bits");
   end

   ctl_t              ctl;
   logic [DATA_W-1:0] as_res, cmp_res, bge_res;
   logic              as_ovf;

   iacu_decode u_dec (
      .func (func),
      .ctl  (ctl)
   );

   iacu_addsub #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_as (
      .a     (opa),
      .b     (opb),
      .sub   (ctl.kind == K_SUB),
      .lw    (ctl.lw),
      .shamt (ctl.shamt),
      .chk   (ctl.chk),
      .res   (as_res),
      .ovf   (as_ovf)
   );

   iacu_cmp #(.DATA_W(DATA_W)) u_cmp (
      .a    (opa),
      .b    (opb),
      .kind (ctl.kind),
      .res  (cmp_res)
   );

   iacu_bytecmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_bge (
      .a   (opa),
      .b   (opb),
      .res (bge_res)
   );

   always_comb begin
      result   = '0;
      ovf_trap = 1'b0;
      bad_func = 1'b0;
      unique case (ctl.kind)
         K_ADD, K_SUB: begin
            result   = as_res;
            ovf_trap = as_ovf;
         end
         K_CEQ, K_CLT, K_CLE, K_CULT, K_CULE: result = cmp_res;
         K_BGE:   result = bge_res;
         default: bad_func = 1'b1;
      endcase
   end
endmodule

// File: rtl/iacu_chk.sv
module iacu_chk #(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32
) (
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [6:0]        func,
   input logic [DATA_W-1:0] result,
   input logic              ovf_trap,
   input logic              bad_func
);
   logic known, is_chk, is_long, is_cmp;

   always_comb begin
      known   = !$isunknown({opa, opb, func, result, ovf_trap, bad_func});
      is_chk  = (func == 7'h40) || (func == 7'h60) || (func == 7'h49) || (func == 7'h69);
      is_long = (func == 7'h00) || (func == 7'h02) || (func == 7'h12) || (func == 7'h40) ||
                (func == 7'h09) || (func == 7'h0b) || (func == 7'h1b) || (func == 7'h49);
      is_cmp  = (func == 7'h2d) || (func == 7'h4d) || (func == 7'h6d) ||
                (func == 7'h1d) || (func == 7'h3d);
   end

   always_comb begin
      if (known) begin
         p_flags_excl_r9: assert (!(ovf_trap && bad_func))
            else $error("p_flags_excl_r9: both flags set");
         p_bad_zero_r9: assert (!bad_func || result == '0)
            else $error("p_bad_zero_r9: nonzero result on bad code");
         p_no_overflow_r6: assert (!ovf_trap || is_chk)
            else $error("p_no_overflow_r6: flag on non-checking code");
         p_long_sext_r1: assert (!is_long || result[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){result[WORD_W-1]}})
            else $error("p_long_sext_r1: longword result not sign-extended");
         p_cmp_bool_r7: assert (!is_cmp || result[DATA_W-1:1] == '0)
            else $error("p_cmp_bool_r7: compare result not 0/1");
         p_eq_self_r7: assert (!(func == 7'h2d && opa == opb) || result == 64'd1)
            else $error("p_eq_self_r7: equal operands not reported equal");
         p_byte_upper_r8: assert (func != 7'h0f || result[DATA_W-1:8] == '0)
            else $error("p_byte_upper_r8: upper bits of byte mask set");
      end
   end
endmodule

bind iacu_top iacu_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
   .opa      (opa),
   .opb      (opb),
   .func     (func),
   .result   (result),
   .ovf_trap (ovf_trap),
   .bad_func (bad_func)
);

// File: tb/tb_iacu_top.sv
module tb_iacu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] opa = '0, opb = '0;
   logic [6:0]  func = '0;
   logic [63:0] result;
   logic        ovf_trap, bad_func;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   iacu_top dut (
      .opa(opa), .opb(opb), .func(func),
      .result(result), .ovf_trap(ovf_trap), .bad_func(bad_func)
   );

   typedef struct {
      logic [63:0] r;
      logic        ov;
      logic        il;
      string       tag;
   } item_t;

   item_t sb[$];

   function automatic void model(input logic [63:0] a, b, input logic [6:0] f,
                                 output logic [63:0] r, output logic ov, output logic il);
      logic [31:0] x32, y32;
      logic [63:0] x64;
      logic        lng, sb_, ck, ar;
      int          sh;
      r = '0; ov = 0; il = 0; ar = 1; lng = 0; sb_ = 0; ck = 0; sh = 0;
      case (f)
         7'h00: lng = 1;
         7'h20: ;
         7'h02: begin lng = 1; sh = 2; end
         7'h12: begin lng = 1; sh = 3; end
         7'h22: sh = 2;
         7'h32: sh = 3;
         7'h40: begin lng = 1; ck = 1; end
         7'h60: ck = 1;
         7'h09: begin lng = 1; sb_ = 1; end
         7'h29: sb_ = 1;
         7'h0b: begin lng = 1; sb_ = 1; sh = 2; end
         7'h1b: begin lng = 1; sb_ = 1; sh = 3; end
         7'h2b: begin sb_ = 1; sh = 2; end
         7'h3b: begin sb_ = 1; sh = 3; end
         7'h49: begin lng = 1; sb_ = 1; ck = 1; end
         7'h69: begin sb_ = 1; ck = 1; end
         default: ar = 0;
      endcase
      if (ar) begin
         if (lng) begin
            x32 = a[31:0] << sh;
            y32 = sb_ ? x32 - b[31:0] : x32 + b[31:0];
            r = {{32{y32[31]}}, y32};
            if (ck) ov = (sb_ ? (a[31] != b[31]) : (a[31] == b[31])) && (y32[31] != a[31]);
         end else begin
            x64 = a << sh;
            r = sb_ ? x64 - b : x64 + b;
            if (ck) ov = (sb_ ? (a[63] != b[63]) : (a[63] == b[63])) && (r[63] != a[63]);
         end
         return;
      end
      case (f)
         7'h2d: r = {63'd0, a == b};
         7'h4d: r = {63'd0, $signed(a) < $signed(b)};
         7'h6d: r = {63'd0, $signed(a) <= $signed(b)};
         7'h1d: r = {63'd0, a < b};
         7'h3d: r = {63'd0, a <= b};
         7'h0f: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
         default: il = 1;
      endcase
   endfunction

   function automatic string tag_of(input logic [6:0] f);
      case (f)
         7'h00, 7'h20: return "R1";
         7'h09, 7'h29: return "R2";
         7'h02, 7'h12, 7'h22, 7'h32, 7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R3";
         7'h40, 7'h60: return "R4";
         7'h49, 7'h69: return "R5";
         7'h2d, 7'h4d, 7'h6d, 7'h1d, 7'h3d: return "R7";
         7'h0f: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic drive(input logic [63:0] a, b, input logic [6:0] f,
                        input logic [63:0] er, input logic eo, input logic ei, input string tag);
      item_t it;
      @(posedge clk);
      opa = a; opb = b; func = f;
      it.r = er; it.ov = eo; it.il = ei; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic drive_m(input logic [63:0] a, b, input logic [6:0] f, input string tag);
      logic [63:0] r; logic o, i;
      model(a, b, f, r, o, i);
      drive(a, b, f, r, o, i, tag);
   endtask

   // Monitor: compare on the falling edge, away from input changes.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (result !== it.r || ovf_trap !== it.ov || bad_func !== it.il) begin
            errors++;
            $display("FAIL %s func=%h: got r=%h ov=%b il=%b expected r=%h ov=%b il=%b",
                     it.tag, func, result, ovf_trap, bad_func, it.r, it.ov, it.il);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [6:0] CODES [0:24] = '{
      7'h00, 7'h20, 7'h09, 7'h29, 7'h02, 7'h12, 7'h22, 7'h32, 7'h0b, 7'h1b,
      7'h2b, 7'h3b, 7'h40, 7'h60, 7'h49, 7'h69, 7'h2d, 7'h4d, 7'h6d, 7'h1d,
      7'h3d, 7'h0f, 7'h01, 7'h7f, 7'h41 };

   initial begin
      logic [63:0] s, a, b;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: zero inputs, code 0
      drive(64'd0, 64'd0, 7'h00, 64'd0, 0, 0, "R1");
      // R1 wrap and sign extension
      drive(64'h7fffffff, 64'd1, 7'h00, 64'hffffffff80000000, 0, 0, "R6");
      drive(64'hffffffffffffffff, 64'd1, 7'h20, 64'd0, 0, 0, "R1");
      drive(64'h0000000500000003, 64'h0000000100000004, 7'h00, 64'd7, 0, 0, "R1");
      // R2
      drive(64'd0, 64'd1, 7'h09, 64'hffffffffffffffff, 0, 0, "R2");
      drive(64'd100, 64'd58, 7'h29, 64'd42, 0, 0, "R2");
      // R3 scaled forms
      drive(64'h40000001, 64'd0, 7'h02, 64'd4, 0, 0, "R3");
      drive(64'd1, 64'd5, 7'h32, 64'd13, 0, 0, "R3");
      drive(64'd3, 64'd20, 7'h2b, 64'hfffffffffffffff8, 0, 0, "R3");
      drive(64'h10000000, 64'd1, 7'h1b, 64'h7fffffff, 0, 0, "R3");
      // R4 add overflow, wrapped result kept (R6)
      drive(64'h7fffffff, 64'd1, 7'h40, 64'hffffffff80000000, 1, 0, "R4");
      drive(64'h7fffffffffffffff, 64'd1, 7'h60, 64'h8000000000000000, 1, 0, "R4");
      drive(64'h7fffffffffffffff, 64'd1, 7'h20, 64'h8000000000000000, 0, 0, "R6");
      drive(64'd5, 64'hffffffffffffffff, 7'h60, 64'd4, 0, 0, "R4");
      // R5 subtract overflow
      drive(64'h80000000, 64'd1, 7'h49, 64'h7fffffff, 1, 0, "R5");
      drive(64'd0, 64'h8000000000000000, 7'h69, 64'h8000000000000000, 1, 0, "R5");
      drive(64'd5, 64'd3, 7'h69, 64'd2, 0, 0, "R5");
      drive(64'd0, 64'h8000000000000000, 7'h29, 64'h8000000000000000, 0, 0, "R6");
      // R7 compares
      drive(64'hffffffffffffffff, 64'd0, 7'h4d, 64'd1, 0, 0, "R7");
      drive(64'hffffffffffffffff, 64'd0, 7'h1d, 64'd0, 0, 0, "R7");
      drive(64'd9, 64'd9, 7'h6d, 64'd1, 0, 0, "R7");
      drive(64'd9, 64'd9, 7'h4d, 64'd0, 0, 0, "R7");
      drive(64'd5, 64'd4, 7'h3d, 64'd0, 0, 0, "R7");
      drive(64'd4, 64'd4, 7'h3d, 64'd1, 0, 0, "R7");
      drive(64'h1234, 64'h1234, 7'h2d, 64'd1, 0, 0, "R7");
      drive(64'h1234, 64'h1235, 7'h2d, 64'd0, 0, 0, "R7");
      // R8 byte mask
      drive(64'h00ff102030405060, 64'h01001020ff000070, 7'h0f, 64'h76, 0, 0, "R8");
      drive(64'hffffffffffffffff, 64'hffffffffffffffff, 7'h0f, 64'hff, 0, 0, "R8");
      // R9 illegal codes
      drive(64'h1111, 64'h2222, 7'h01, 64'd0, 0, 1, "R9");
      drive(64'h7fffffffffffffff, 64'd1, 7'h7f, 64'd0, 0, 1, "R9");
      drive(64'h7fffffff, 64'd1, 7'h41, 64'd0, 0, 1, "R9");
      // random mix over all codes
      s = 64'h9e3779b97f4a7c15;
      for (int n = 0; n < 400; n++) begin
         s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
         a = s;
         s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
         b = s;
         if (n % 4 == 1) b = {56'd0, b[7:0]};
         if (n % 5 == 2) b = a ^ {1'b1, 63'd0};
         drive_m(a, b, CODES[n % 25], tag_of(CODES[n % 25]));
      end
      repeat (3) @(posedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule